// File: doc/BRIEF.md
# Callee-Saved Register Stack Sequencer

This block carries out compressed push and pop instructions that spill or restore a group of callee-saved registers together with the return address. A decoder upstream hands it one request: the operation kind, a 4-bit list code, a 2-bit extra-frame field and two mode flags. The mode flags select 32-bit or 64-bit registers and the reduced 16-register base. The block expands the list code into a register bitmap. It works out the stack frame size and then walks the selected registers from the highest number down. It makes one memory access per register through a request/acknowledge port.

For a push, the block reads each register through a register-file read port and stores it. For a pop, each loaded word goes straight to the register-file write port. Once every access has been acknowledged, the block optionally clears a0 and writes back the adjusted stack pointer. For the returning pop forms, it also hands a redirect target (the restored return address) to the fetch logic. It runs one request at a time and reports busy and done.

Top module: `regstack_seq`

## Requirements
- R1: For a legal list code c, `reg_mask` holds bit i set for each selected register xi from the cycle after acceptance. Code 4 selects x1. Code 5 adds x8. Code 6 adds x9. Each of codes 7..14 adds one more of x18..x25 in rising order. Code 15 adds both x26 and x27. The count of set bits is c-3, or 13 for code 15.
- R2: A request with list code 0..3 is rejected. `illegal` pulses for the one cycle after acceptance, `busy` stays low and no memory access is issued.
- R3: With `req_reduced`=1, any list code above 6 is rejected in the same way as in R2.
- R4: The frame size is the register count times the register size (4 bytes when `req_wide`=0, 8 when `req_wide`=1), rounded up to a multiple of 16. The total adjustment adds `req_spimm`×16 to the frame size.
- R5: For a push (`req_op`=0), the stores go from the highest selected register down. The first address is sp−size and each later address is one size lower. `mem_we`=1, and `mem_wdata` carries the register value read on `rf_rd_idx` (in 32-bit mode only the low 32 bits, upper bits zero).
- R6: For a pop (`req_op`=1, 2 or 3), the loads go in the same order. The first address is sp+adjustment−size and each later address is one size lower. In the cycle of each acknowledge, the loaded value is written to that register (in 32-bit mode it is zero-extended from 32 bits).
- R7: In the done cycle, `rf_wr_en` writes x2 with sp−adjustment after a push and with sp+adjustment after a pop. This happens only after every access has been acknowledged.
- R8: For `req_op`=3, x10 is written with zero in the cycle after the last acknowledge, which is one cycle before done.
- R9: For `req_op`=2 or 3, `redirect_valid` is high in the done cycle and `redirect_pc` equals the value just restored into x1. For other operations, `redirect_valid` stays low.
- R10: While `mem_req` is high and `mem_ack` is low, the request and `mem_addr` hold steady into the next cycle.
- R11: `busy` is high from the cycle after acceptance through the done cycle. `done` is a one-cycle pulse. A request presented while busy is ignored and does not change `reg_mask` or the access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken when idle) |
| req_op | input | 2 | 0 push, 1 pop, 2 pop+return, 3 pop+return+clear a0 |
| req_rlist | input | 4 | Register-list code |
| req_spimm | input | 2 | Extra frame, in units of 16 bytes |
| req_wide | input | 1 | 1: 64-bit registers, 0: 32-bit |
| req_reduced | input | 1 | Reduced 16-register base active |
| sp_in | input | XLEN | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of a sequence |
| illegal | output | 1 | Request rejected |
| reg_mask | output | 32 | Selected-register bitmap |
| rf_rd_idx | output | 5 | Register-file read index |
| rf_rd_data | input | XLEN | Register-file read data |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | XLEN | Register-file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 store, 0 load |
| mem_wide | output | 1 | Access size: 1 is 8 bytes, 0 is 4 bytes |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Store data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | XLEN | Load data, valid with ack |
| redirect_valid | output | 1 | Return redirect |
| redirect_pc | output | XLEN | Redirect target |

## Verification
A request is taken at the edge where it is valid and idle. The next cycle already shows `busy`, `reg_mask` and the first `mem_req`, or the `illegal` pulse. Each register's load write happens in the same cycle as its acknowledge. The next address appears one cycle after the acknowledge, the a0 clear comes one cycle after the last acknowledge, and done with the sp write one cycle after that. The bench stretches each access by 0, 1 or 2 wait cycles, and it samples outputs at the falling edge (and 1 time unit after driving an acknowledge). This lets it match every one of these cycles exactly against its own list-driven model.

// File: rtl/regstack_pkg.sv
`timescale 1ns/1ps
package regstack_pkg;
    localparam int unsigned NREG   = 32;
    localparam int unsigned IDX_W  = 5;
    localparam int unsigned CNT_W  = 4;
    localparam int unsigned ADJ_W  = 8;
    localparam logic [IDX_W-1:0] RA_IDX = 5'd1;
    localparam logic [IDX_W-1:0] SP_IDX = 5'd2;
    localparam logic [IDX_W-1:0] A0_IDX = 5'd10;

    typedef enum logic [1:0] {
        OP_PUSH    = 2'd0,
        OP_POP     = 2'd1,
        OP_POPRET  = 2'd2,
        OP_POPRETZ = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_CLR  = 2'd2,
        ST_SPWB = 2'd3
    } stk_state_e;

    // lowest list code that selects register b (16 = never)
    function automatic int sel_threshold(int b);
        if (b == 1)                 return 4;
        else if (b == 8)            return 5;
        else if (b == 9)            return 6;
        else if (b >= 18 && b <= 25) return b - 11;
        else if (b == 26 || b == 27) return 15;
        else                        return 16;
    endfunction
endpackage

// File: rtl/regstack_list_decode.sv
`timescale 1ns/1ps
module regstack_list_decode
    import regstack_pkg::*;
(
    input  logic [3:0]       code,
    input  logic             reduced,
    output logic [NREG-1:0]  mask,
    output logic [CNT_W-1:0] cnt,
    output logic             legal
);
    // one comparator per register against its entry threshold
    for (genvar b = 0; b < NREG; b++) begin : g_bit
        localparam int TH = sel_threshold(b);
        assign mask[b] = ({1'b0, code} >= 5'(TH));
    end

    always_comb begin
        if (code < 4'd4)       cnt = '0;
        else if (code == 4'd15) cnt = CNT_W'(13);
        else                   cnt = code - 4'd3;
    end

    assign legal = (code >= 4'd4) && !(reduced && (code > 4'd6));
endmodule

// File: rtl/regstack_frame.sv
`timescale 1ns/1ps
module regstack_frame
    import regstack_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             wide,
    input  logic [1:0]       spimm,
    output logic [ADJ_W-1:0] adj,
    output logic [XLEN-1:0]  size
);
    localparam logic [ADJ_W-1:0] ALIGN_M = ADJ_W'(15);

    logic [ADJ_W-1:0] raw_bytes;
    logic [ADJ_W-1:0] rounded;

    always_comb begin
        raw_bytes = wide ? (ADJ_W'(cnt) << 3) : (ADJ_W'(cnt) << 2);
        rounded   = (raw_bytes + ALIGN_M) & ~ALIGN_M;
        adj       = rounded + ADJ_W'({spimm, 4'b0000});
        size      = wide ? XLEN'(8) : XLEN'(4);
    end
endmodule

// File: rtl/regstack_pick_top.sv
`timescale 1ns/1ps
module regstack_pick_top
    import regstack_pkg::*;
(
    input  logic [NREG-1:0]  pending,
    output logic [IDX_W-1:0] top_idx
);
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (pending[i]) top_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/regstack_seq.sv
`timescale 1ns/1ps
module regstack_seq
    import regstack_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [3:0]       req_rlist,
    input  logic [1:0]       req_spimm,
    input  logic             req_wide,
    input  logic             req_reduced,
    input  logic [XLEN-1:0]  sp_in,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic [31:0]      reg_mask,
    output logic [4:0]       rf_rd_idx,
    input  logic [XLEN-1:0]  rf_rd_data,
    output logic             rf_wr_en,
    output logic [4:0]       rf_wr_idx,
    output logic [XLEN-1:0]  rf_wr_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc
);
    typedef struct packed {
        stk_state_e       st;
        logic [NREG-1:0]  rem;
        logic [NREG-1:0]  mask;
        stk_op_e          op;
        logic             wide;
        logic [XLEN-1:0]  sp;
        logic [XLEN-1:0]  addr;
        logic [ADJ_W-1:0] adj;
        logic [XLEN-1:0]  ra;
        logic             illegal;
    } ctx_t;

    ctx_t q, d;

    logic [NREG-1:0]  dec_mask;
    logic [CNT_W-1:0] dec_cnt;
    logic             dec_legal;
    logic [ADJ_W-1:0] req_adj;
    logic [XLEN-1:0]  req_size;
    logic [IDX_W-1:0] top_idx;
    logic [NREG-1:0]  rem_left;
    logic [XLEN-1:0]  q_size;
    logic [XLEN-1:0]  load_val;
    logic [XLEN-1:0]  sp_final;
    logic             is_push_q;

    function automatic logic [XLEN-1:0] fit_width(logic [XLEN-1:0] v, logic wide);
        return wide ? v : {{(XLEN-32){1'b0}}, v[31:0]};
    endfunction

    regstack_list_decode u_decode (
        .code    (req_rlist),
        .reduced (req_reduced),
        .mask    (dec_mask),
        .cnt     (dec_cnt),
        .legal   (dec_legal)
    );

    regstack_frame #(.XLEN(XLEN)) u_frame (
        .cnt   (dec_cnt),
        .wide  (req_wide),
        .spimm (req_spimm),
        .adj   (req_adj),
        .size  (req_size)
    );

    regstack_pick_top u_pick (
        .pending (q.rem),
        .top_idx (top_idx)
    );

    assign is_push_q = (q.op == OP_PUSH);
    assign q_size    = q.wide ? XLEN'(8) : XLEN'(4);
    assign rem_left  = q.rem & ~(NREG'(1) << top_idx);
    assign load_val  = fit_width(mem_rdata, q.wide);
    assign sp_final  = is_push_q ? (q.sp - XLEN'(q.adj)) : (q.sp + XLEN'(q.adj));

    always_comb begin
        d = q;
        d.illegal = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!dec_legal) begin
                        d.illegal = 1'b1;
                    end else begin
                        d.st   = ST_XFER;
                        d.rem  = dec_mask;
                        d.mask = dec_mask;
                        d.op   = stk_op_e'(req_op);
                        d.wide = req_wide;
                        d.sp   = sp_in;
                        d.adj  = req_adj;
                        d.addr = (stk_op_e'(req_op) == OP_PUSH)
                               ? (sp_in - req_size)
                               : (sp_in + XLEN'(req_adj) - req_size);
                    end
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    d.rem  = rem_left;
                    d.addr = q.addr - q_size;
                    if (!is_push_q && (top_idx == RA_IDX)) d.ra = load_val;
                    if (rem_left == '0) d.st = (q.op == OP_POPRETZ) ? ST_CLR : ST_SPWB;
                end
            end
            ST_CLR:  d.st = ST_SPWB;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy           = (q.st != ST_IDLE);
        done           = (q.st == ST_SPWB);
        illegal        = q.illegal;
        reg_mask       = q.mask;
        redirect_valid = done && ((q.op == OP_POPRET) || (q.op == OP_POPRETZ));
        redirect_pc    = q.ra;
        mem_req        = (q.st == ST_XFER);
        mem_we         = is_push_q;
        mem_wide       = q.wide;
        mem_addr       = q.addr;
        mem_wdata      = fit_width(rf_rd_data, q.wide);
        rf_rd_idx      = top_idx;
        rf_wr_en       = 1'b0;
        rf_wr_idx      = top_idx;
        rf_wr_data     = load_val;
        unique case (q.st)
            ST_XFER: rf_wr_en = mem_ack && !is_push_q;
            ST_CLR: begin
                rf_wr_en   = 1'b1;
                rf_wr_idx  = A0_IDX;
                rf_wr_data = '0;
            end
            ST_SPWB: begin
                rf_wr_en   = 1'b1;
                rf_wr_idx  = SP_IDX;
                rf_wr_data = sp_final;
            end
            default: ;
        endcase
    end

    // list bitmap population matches the count used for the frame
    assert_mask_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && dec_legal) |=> ($countones(reg_mask) == $past(int'(dec_cnt))));

    assert_short_list_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_rlist < 4'd4)) |=> (illegal && !busy && !mem_req));

    assert_reduced_rejected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_reduced && (req_rlist > 4'd6)) |=> (illegal && !busy));

    // consecutive accesses step down by one register size
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && ($countones(q.rem) > 1))
        |=> (mem_req && (mem_addr == $past(mem_addr) - (mem_wide ? XLEN'(8) : XLEN'(4)))));

    assert_sp_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && rf_wr_en && (rf_wr_idx == SP_IDX)));

    assert_zero_before_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_req && !done) |=> done);

    assert_redirect_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> done);

    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

// File: tb/test_regstack_seq.sv
`timescale 1ns/1ps
module test_regstack_seq;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_op = '0;
    logic [3:0]      req_rlist = '0;
    logic [1:0]      req_spimm = '0;
    logic            req_wide = 1'b0;
    logic            req_reduced = 1'b0;
    logic [XLEN-1:0] sp_in;
    logic            busy, done, illegal;
    logic [31:0]     reg_mask;
    logic [4:0]      rf_rd_idx;
    logic [XLEN-1:0] rf_rd_data;
    logic            rf_wr_en;
    logic [4:0]      rf_wr_idx;
    logic [XLEN-1:0] rf_wr_data;
    logic            mem_req, mem_we, mem_wide;
    logic [XLEN-1:0] mem_addr, mem_wdata;
    logic            mem_ack = 1'b0;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;

    logic [63:0] regs [32];
    logic [63:0] mem [logic [63:0]];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign rf_rd_data = regs[rf_rd_idx];
    assign sp_in      = regs[2];

    regstack_seq #(.XLEN(XLEN)) i_regstack_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_rlist(req_rlist), .req_spimm(req_spimm), .req_wide(req_wide),
        .req_reduced(req_reduced), .sp_in(sp_in), .busy(busy), .done(done),
        .illegal(illegal), .reg_mask(reg_mask), .rf_rd_idx(rf_rd_idx),
        .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] narrow(logic [63:0] v, bit wide);
        return wide ? v : {32'h0, v[31:0]};
    endfunction

    task automatic scramble();
        for (int i = 1; i < 32; i++)
            if (i != 2) regs[i] = regs[i] ^ (64'hF0F0_3C3C_0FF0_5A5A + 64'(i * 3));
    endtask

    // op: 0 push, 1 pop, 2 pop+ret, 3 pop+ret+zero
    task automatic run(int op, int code, int spimm, bit wide, bit red, int wpat, bit poke);
        int order [13] = '{1, 8, 9, 18, 19, 20, 21, 22, 23, 24, 25, 26, 27};
        int lst [$];
        int n, size, adj;
        bit legal;
        logic [63:0] sp, addr, nsp, v, emask;
        string tag;
        legal = (code >= 4) && !(red && code > 6);
        n = !legal ? 0 : (code == 15 ? 13 : code - 3);
        for (int i = 0; i < n; i++) lst.push_front(order[i]);
        size = wide ? 8 : 4;
        adj  = ((n * size + 15) / 16) * 16 + spimm * 16;
        sp   = regs[2];
        addr = (op == 0) ? sp - 64'(size) : sp + 64'(adj) - 64'(size);
        nsp  = (op == 0) ? sp - 64'(adj) : sp + 64'(adj);
        tag  = (op == 0) ? "R5" : "R6";
        emask = '0;
        foreach (lst[i]) emask[lst[i]] = 1'b1;

        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_rlist = 4'(code);
        req_spimm = 2'(spimm); req_wide = wide; req_reduced = red;
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal) begin
            chk(red ? "R3 illegal pulse" : "R2 illegal pulse", 64'(illegal), 64'd1);
            chk("R2 no busy on reject", 64'(busy), 64'd0);
            chk("R2 no access on reject", 64'(mem_req), 64'd0);
            @(negedge clk);
            chk("R2 illegal one cycle", 64'(illegal), 64'd0);
            chk("R3 still idle", 64'(busy), 64'd0);
            return;
        end
        chk("R1 reg_mask", 64'(reg_mask), emask);
        chk("R11 busy after accept", 64'(busy), 64'd1);
        foreach (lst[j]) begin
            int r = lst[j];
            int w = (wpat + j) % 3;
            for (int c = 0; c <= w; c++) begin
                chk("R10 mem_req", 64'(mem_req), 64'd1);
                chk({tag, " addr"}, mem_addr, addr);
                chk({tag, " dir"}, 64'(mem_we), 64'(op == 0));
                chk("R4 access size", 64'(mem_wide), 64'(wide));
                chk("R11 no early done", 64'(done), 64'd0);
                req_valid = poke && (j == 0) && (c == 0);
                if (req_valid) begin
                    req_op = 2'd0; req_rlist = 4'd15; req_spimm = 2'd3;
                end
                if (c == w) begin
                    mem_ack = 1'b1;
                    if (op != 0) begin
                        v = mem.exists(addr) ? mem[addr] : 64'h0;
                        mem_rdata = v;
                        #1;
                        chk("R6 load write en", 64'(rf_wr_en), 64'd1);
                        chk("R6 load write idx", 64'(rf_wr_idx), 64'(r));
                        chk("R6 load write data", rf_wr_data, narrow(v, wide));
                        regs[r] = narrow(v, wide);
                    end else begin
                        #1;
                        chk("R5 read idx", 64'(rf_rd_idx), 64'(r));
                        chk("R5 store data", mem_wdata, narrow(regs[r], wide));
                        mem[addr] = narrow(regs[r], wide);
                    end
                end else begin
                    mem_ack = 1'b0;
                    #1;
                    chk("R10 no write while waiting", 64'(rf_wr_en), 64'd0);
                end
                @(negedge clk);
                mem_ack = 1'b0;
                req_valid = 1'b0;
            end
            addr = addr - 64'(size);
        end
        if (op == 3) begin
            chk("R8 a0 clear en", 64'(rf_wr_en), 64'd1);
            chk("R8 a0 clear idx", 64'(rf_wr_idx), 64'd10);
            chk("R8 a0 clear data", rf_wr_data, 64'd0);
            chk("R8 done not yet", 64'(done), 64'd0);
            chk("R8 after accesses", 64'(mem_req), 64'd0);
            regs[10] = '0;
            @(negedge clk);
        end
        chk("R11 done", 64'(done), 64'd1);
        chk("R7 no access at done", 64'(mem_req), 64'd0);
        chk("R7 sp write en", 64'(rf_wr_en), 64'd1);
        chk("R7 sp write idx", 64'(rf_wr_idx), 64'd2);
        chk("R4 R7 sp value", rf_wr_data, nsp);
        chk("R9 redirect valid", 64'(redirect_valid), 64'(op >= 2));
        if (op >= 2) chk("R9 redirect pc", redirect_pc, regs[1]);
        regs[2] = nsp;
        @(negedge clk);
        chk("R11 done pulse ends", 64'(done), 64'd0);
        chk("R11 idle after done", 64'(busy), 64'd0);
        if (poke) chk("R11 mask kept despite poke", 64'(reg_mask), emask);
    endtask

    initial begin
        for (int i = 0; i < 32; i++)
            regs[i] = {32'hA500_0000 + 32'(i * 17), 32'h1357_0000 + 32'(i * 291)};
        regs[0] = '0;
        regs[2] = 64'h0000_0000_0004_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", 64'(busy), 64'd0);
        chk("R11 reset done", 64'(done), 64'd0);
        chk("R10 reset mem_req", 64'(mem_req), 64'd0);
        chk("R2 reset illegal", 64'(illegal), 64'd0);
        chk("R1 reset mask", 64'(reg_mask), 64'd0);
        chk("R9 reset redirect", 64'(redirect_valid), 64'd0);

        run(0, 15, 1, 1'b1, 1'b0, 0, 1'b0);
        scramble();
        run(2, 15, 1, 1'b1, 1'b0, 1, 1'b0);
        run(0, 4, 0, 1'b0, 1'b0, 2, 1'b0);
        run(0, 7, 3, 1'b0, 1'b0, 0, 1'b0);
        scramble();
        run(3, 7, 3, 1'b0, 1'b0, 1, 1'b0);
        run(1, 4, 0, 1'b0, 1'b0, 0, 1'b0);
        run(0, 6, 2, 1'b1, 1'b1, 2, 1'b0);
        scramble();
        run(1, 6, 2, 1'b1, 1'b1, 0, 1'b0);
        run(0, 2, 0, 1'b1, 1'b0, 0, 1'b0);
        run(1, 0, 1, 1'b0, 1'b0, 0, 1'b0);
        run(0, 9, 0, 1'b1, 1'b1, 0, 1'b0);
        run(0, 12, 0, 1'b1, 1'b0, 1, 1'b1);
        scramble();
        run(3, 12, 0, 1'b1, 1'b0, 2, 1'b0);
        run(0, 13, 2, 1'b0, 1'b0, 1, 1'b0);
        scramble();
        run(2, 13, 2, 1'b0, 1'b0, 0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule